// File: doc/BRIEF.md
# Interval-latched alarm status register

This block holds the alarm and status word of a line or physical-layer receiver and returns it to a host through a read strobe. It has two modes. In live mode, a read returns the alarm inputs as they are in that cycle. In interval mode, an external one-second tick divides time into intervals. Every alarm bit that is high in any cycle of an interval is accumulated, and the accumulated word is presented during the following interval.

The tick is asynchronous to the block's clock. It passes through a two-flop synchronizer and a rising-edge detector. At each detected edge, the accumulated shadow word moves into the held word, and a fresh accumulation begins.

Reads in interval mode follow a first-read and repeat-read rule:
- The first read after a boundary returns the held word and leaves it in place.
- Any later read in the same interval returns the live inputs and clears the held word.

Top module: `alarm_interval_latch`

## Requirements
- R1: After reset, rdata_o is 0 and the held, shadow and read-count state are cleared. A first read in interval mode before any tick therefore returns 0.
- R2: With latch_en_i low, a read samples alarm_i at the clock edge where rd_i is high. That value appears on rdata_o from that edge on.
- R3: rdata_o changes only at an edge where rd_i is high. Without a read it holds its value whatever alarm_i does.
- R4: An interval boundary is a rising edge of tick_i. The boundary takes effect at the third clock edge that samples tick_i high; alarm_i at that edge still belongs to the ending interval. Holding tick_i high makes no further boundary.
- R5: At a boundary, the held word becomes the bitwise OR of alarm_i over every clock edge of the ending interval.
- R6: In interval mode, the first read after a boundary returns the held word and does not clear it. The held word changes only at a boundary or on a clearing read.
- R7: In interval mode, a second or later read in the same interval returns live alarm_i and clears the held word. Driving latch_en_i low for a cycle resets the read count, so the next read is a first read again.
- R8: When a boundary and a clearing read fall on the same edge:
  - the read returns live alarm_i;
  - the held word takes the new interval data, not zero;
  - the read count restarts, so the next read is a first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alarm_i | input | W | Alarm and status inputs |
| tick_i | input | 1 | One-second interval tick, asynchronous |
| latch_en_i | input | 1 | 1 = interval mode, 0 = live mode |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | W | Read data, registered |

## Verification
The in-module assertions check every cycle for the following:
- a detected tick lasts a single cycle;
- the held word stays unchanged outside boundaries and clearing reads;
- a clear without a boundary zeroes the held word;
- live-mode reads return the sampled inputs;
- rdata_o holds between reads;
- leaving interval mode resets the read count.

Only the bench scenarios can show the rest:
- sticky accumulation of short alarm pulses across an interval;
- the three-edge boundary latency;
- a tick held high producing no new boundary;
- the priority of a boundary over a same-edge clear.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int unsigned RD_CNT_W = 2;
  typedef logic [RD_CNT_W-1:0] rd_cnt_t;
  localparam rd_cnt_t RD_CNT_MAX = '1;
endpackage

// File: rtl/tick_edge_sync.sv
module tick_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic edge_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tick_i};
  end

  assign edge_o = sync_q[1] & ~sync_q[2];

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o); // R4
endmodule

// File: rtl/read_tracker.sv
module read_tracker
  import alm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic latch_en_i,
  input  logic tick_i,
  input  logic rd_i,
  output logic first_o
);
  rd_cnt_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!latch_en_i || tick_i)       cnt_q <= '0;
    else if (rd_i && cnt_q != RD_CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign first_o = (cnt_q == '0);

  AST_MODE_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_en_i |=> first_o); // R7
  AST_TICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> first_o); // R8
endmodule

// File: rtl/alarm_accum.sv
module alarm_accum #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] alarm_i,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic [W-1:0] held_o
);
  logic [W-1:0] shadow_q, held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      held_q   <= '0;
    end else if (tick_i) begin
      // boundary edge sample closes the old interval; boundary beats clear
      held_q   <= shadow_q | alarm_i;
      shadow_q <= '0;
    end else begin
      shadow_q <= shadow_q | alarm_i;
      if (clr_i) held_q <= '0;
    end
  end

  assign held_o = held_q;

  AST_HELD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(held_o)); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !tick_i) |=> (held_o == '0)); // R7
endmodule

// File: rtl/alarm_interval_latch.sv
module alarm_interval_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] alarm_i,
  input  logic         tick_i,
  input  logic         latch_en_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o
);
  logic         tick_edge;
  logic         first_rd;
  logic         clr_rd;
  logic [W-1:0] held;
  logic [W-1:0] rdata_q;

  tick_edge_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .edge_o (tick_edge)
  );

  read_tracker u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .latch_en_i (latch_en_i),
    .tick_i     (tick_edge),
    .rd_i       (rd_i),
    .first_o    (first_rd)
  );

  assign clr_rd = rd_i & latch_en_i & ~first_rd;

  alarm_accum #(.W(W)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alarm_i (alarm_i),
    .tick_i  (tick_edge),
    .clr_i   (clr_rd),
    .held_o  (held)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_i) rdata_q <= (latch_en_i && first_rd) ? held : alarm_i;
  end

  assign rdata_o = rdata_q;

  AST_LIVE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !latch_en_i) |=> (rdata_o == $past(alarm_i))); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R3
  AST_REPEAT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rd |=> (rdata_o == $past(alarm_i))); // R7
endmodule

// File: tb/alarm_interval_latch_test.sv
module alarm_interval_latch_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] alarm = '0;
  logic         tick = 1'b0;
  logic         latch_en = 1'b0;
  logic         rd = 1'b0;
  logic [W-1:0] rdata;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] prev_live;
  logic [W-1:0] expv;

  always #10 clk = ~clk;

  alarm_interval_latch #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .alarm_i(alarm), .tick_i(tick),
    .latch_en_i(latch_en), .rd_i(rd), .rdata_o(rdata)
  );

  // {pulse_a, pulse_b, live_at_boundary}
  localparam logic [23:0] VEC [5] = '{
    24'h01_00_00, 24'h80_04_00, 24'h10_10_20, 24'h00_00_0F, 24'hAA_55_00
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(input string tag, input logic [W-1:0] exp);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(tag, rdata, exp);
  endtask

  // rise, boundary after 3 edges, fall, let synchronizer settle
  task automatic do_tick();
    tick = 1'b1;
    cyc(3);
    tick = 1'b0;
    cyc(3);
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    check("R1 reset rdata", rdata, '0);
    latch_en = 1'b1;
    alarm = 8'h3C;
    do_read("R1 first read after reset", 8'h00);
    latch_en = 1'b0;
    cyc(1);

    alarm = 8'h5A;
    do_read("R2 live read a", 8'h5A);
    alarm = 8'hC3;
    do_read("R2 live read b", 8'hC3);
    alarm = 8'hFF;
    cyc(3);
    check("R3 hold without read", rdata, 8'hC3);

    // flush shadow with a quiet interval
    alarm = '0;
    latch_en = 1'b1;
    do_tick();
    prev_live = '0;

    for (int k = 0; k < 5; k++) begin
      alarm = VEC[k][23:16]; cyc(1);
      alarm = VEC[k][15:8];  cyc(1);
      alarm = '0;            cyc(2);
      alarm = VEC[k][7:0];
      tick = 1'b1;
      cyc(3);
      tick = 1'b0;
      cyc(1);
      expv = VEC[k][23:16] | VEC[k][15:8] | VEC[k][7:0] | prev_live;
      do_read("R5 first read sticky", expv);
      alarm = VEC[k][7:0] ^ 8'h01;
      do_read("R7 second read live", VEC[k][7:0] ^ 8'h01);
      prev_live = VEC[k][7:0] | (VEC[k][7:0] ^ 8'h01);
      alarm = '0;
      cyc(3);
    end

    // R6: first read does not clear; repeated first reads via mode toggle
    alarm = '0;
    do_tick();
    alarm = 8'h21; cyc(1); alarm = '0;
    do_tick();
    do_read("R6 first read", 8'h21);
    latch_en = 1'b0; cyc(1); latch_en = 1'b1;
    do_read("R6 held kept after first read", 8'h21);

    // R4: tick held high makes one boundary only
    tick = 1'b1;
    cyc(3);
    alarm = 8'h40; cyc(1); alarm = '0;
    cyc(4);
    do_read("R4 no boundary while tick high", 8'h00);
    tick = 1'b0;
    cyc(3);
    do_tick();
    do_read("R4 next rising edge is a boundary", 8'h40);

    // R7: clear observable after read-count reset
    alarm = 8'h05;
    do_read("R7 repeat read returns live", 8'h05);
    latch_en = 1'b0; cyc(1); latch_en = 1'b1;
    do_read("R7 held cleared", 8'h00);

    // R8: boundary and clearing read on the same edge
    alarm = 8'h02;
    tick = 1'b1;
    cyc(2);
    do_read("R8 same-edge read is live", 8'h02);
    tick = 1'b0;
    cyc(3);
    do_read("R8 boundary wins over clear", 8'h07);
    do_read("R8 then repeat read live", 8'h02);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule